// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block sits beside the data register of a NAND flash controller and computes a three-byte Hamming-style check code over each 256-byte block. Every byte that software writes to the flash, and every byte it reads from the flash, is folded into a set of line-parity and column-parity bits. A two-bit mode input, taken from the controller's mode register, selects one of four actions: hold, accumulate, read-out or clear.

Software starts a block by selecting clear, then off, then accumulate. To collect the code it selects off, then read-out. It then reads the data register three times and selects off again. In read-out mode, data-register reads return code bytes instead of flash data, and no flash read strobe is issued. Correcting errors from the syndrome is done by software.

Top module: `nand_ecc_accum`

## Requirements
- R1: The code is three bytes over a block of 256 bytes, where each byte has a block address from 0 to 255. Let p be the XOR of the eight bits of a byte.
  - Line parity: for each address bit k (0..7), LP[2k+1] accumulates p of the bytes whose address bit k is 1, and LP[2k] accumulates p of the bytes whose address bit k is 0.
  - Column parity, over the whole block: CP0 = XOR of data bits 0,2,4,6; CP1 = bits 1,3,5,7; CP2 = bits 0,1,4,5; CP3 = bits 2,3,6,7; CP4 = bits 0..3; CP5 = bits 4..7.
  - Code byte 0 = ~LP[7:0]. Code byte 1 = ~LP[15:8]. Code byte 2 = {~CP5,~CP4,~CP3,~CP2,~CP1,~CP0,1,1}, from bit 7 down to bit 0.
- R2: The parity state after reset equals the cleared state. In that state the code reads FF, FF, FF. An all-0xFF block also yields FF, FF, FF.
- R3: The mode input `ecc_mode` is encoded as follows: 2'b00 off, 2'b01 accumulate, 2'b10 read-out, 2'b11 clear. A new value takes effect in the same cycle it is presented.
- R4: In accumulate mode, each cycle with `dr_wr` high folds `dr_wdata`, and each cycle with `dr_rd` high folds `flash_rdata`. If both are high, only the write is folded. Each folded byte advances the block address by one.
- R5: In off mode, bytes written or read through the data register leave the code and the block address unchanged.
- R6: Clear mode sets the parity state and the block address to zero, so the code reads FF, FF, FF.
- R7: In read-out mode, successive `dr_rd` cycles return code byte 1, then code byte 0, then code byte 2 on `dr_rdata`.
- R8: In read-out mode, `flash_rd_stb` stays low and reads do not fold any byte. In every other mode, `flash_rd_stb` follows `dr_rd` and `dr_rdata` equals `flash_rdata`.
- R9: After the third read-out read, the sequence starts again at code byte 1. Any cycle whose mode is not read-out returns the sequence to its first position.
- R10: The block address wraps from 255 to 0. Bytes beyond the 256th keep accumulating at the wrapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_mode | input | 2 | ECC mode field of the mode register |
| dr_wr | input | 1 | Data-register write to the flash this cycle |
| dr_wdata | input | 8 | Byte written to the flash |
| dr_rd | input | 1 | Data-register read this cycle |
| flash_rdata | input | 8 | Byte returned by the flash |
| flash_rd_stb | output | 1 | Read strobe to the flash |
| dr_rdata | output | 8 | Data-register read value (flash byte or code byte) |

## Verification
The read-out path is combinational from the mode input and a position register. The bench therefore drives each read at the falling edge and samples `dr_rdata` and `flash_rd_stb` 1 ns later, in the same cycle. A folded byte, a clear and a position step all land at the following rising edge. For that reason every mode change and transfer is a full cycle before the next sample. Expected codes are recomputed in the bench, bit by bit, from the bytes it sent. The bench then compares them in the 1, 0, 2 order.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int BYTE_W     = 8;
    localparam int BLK_ADDR_W = 8;
    localparam int LP_W       = 2 * BLK_ADDR_W;
    localparam int CP_W       = 6;
    localparam int CODE_BYTES = 3;
    localparam int POS_W      = $clog2(CODE_BYTES);

    typedef enum logic [1:0] {
        ECC_OFF  = 2'b00,
        ECC_ACC  = 2'b01,
        ECC_READ = 2'b10,
        ECC_CLR  = 2'b11
    } ecc_mode_e;

    typedef struct packed {
        logic [LP_W-1:0] lp;
        logic [CP_W-1:0] cp;
    } ecc_par_t;

    // column parity of one byte
    function automatic logic [CP_W-1:0] col_par(input logic [BYTE_W-1:0] b);
        logic [CP_W-1:0] c;
        c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        c[4] = ^b[3:0];
        c[5] = ^b[7:4];
        return c;
    endfunction

    // read-out position to code byte number
    function automatic logic [1:0] read_order(input logic [POS_W-1:0] pos);
        case (pos)
            2'd0:    return 2'd1;
            2'd1:    return 2'd0;
            default: return 2'd2;
        endcase
    endfunction

    // inverted storage view of the parity state
    function automatic logic [BYTE_W-1:0] code_byte(input ecc_par_t p, input logic [1:0] sel);
        case (sel)
            2'd0:    return ~p.lp[7:0];
            2'd1:    return ~p.lp[15:8];
            default: return {~p.cp, 2'b11};
        endcase
    endfunction
endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
    import nand_ecc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  ecc_mode_e             mode,
    input  logic                  fold_en,
    input  logic [BYTE_W-1:0]     fold_byte,
    output ecc_par_t              par
);
    logic [BLK_ADDR_W-1:0] addr;
    logic [LP_W-1:0]       lp_next;
    logic                  bpar;

    assign bpar = ^fold_byte;

    for (genvar k = 0; k < BLK_ADDR_W; k++) begin : g_line
        assign lp_next[2*k+1] = par.lp[2*k+1] ^ (bpar &  addr[k]);
        assign lp_next[2*k]   = par.lp[2*k]   ^ (bpar & ~addr[k]);
    end

    always_ff @(posedge clk) begin
        if (rst || mode == ECC_CLR) begin
            par  <= '0;
            addr <= '0;
        end else if (mode == ECC_ACC && fold_en) begin
            par.lp <= lp_next;
            par.cp <= par.cp ^ col_par(fold_byte);
            addr   <= addr + 1'b1;
        end
    end

    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mode == ECC_OFF |=> $stable(par) && $stable(addr));
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mode == ECC_CLR |=> par == '0 && addr == '0);
    // R10
    addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        mode == ECC_ACC && fold_en && addr == '1 |=> addr == '0);
endmodule

// File: rtl/ecc_readout_seq.sv
module ecc_readout_seq
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ecc_mode_e        mode,
    input  logic             rd,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(CODE_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst || mode != ECC_READ)
            pos <= '0;
        else if (rd)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end

    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        mode != ECC_READ |=> pos == '0);
    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        mode == ECC_READ && rd && pos == LAST |=> pos == '0);
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  ecc_mode,
    input  logic        dr_wr,
    input  logic [7:0]  dr_wdata,
    input  logic        dr_rd,
    input  logic [7:0]  flash_rdata,
    output logic        flash_rd_stb,
    output logic [7:0]  dr_rdata
);
    ecc_mode_e        mode;
    ecc_par_t         par;
    logic [POS_W-1:0] pos;
    logic             fold_en;
    logic [7:0]       fold_byte;

    assign mode      = ecc_mode_e'(ecc_mode);
    assign fold_en   = dr_wr || (dr_rd && mode != ECC_READ);
    assign fold_byte = dr_wr ? dr_wdata : flash_rdata;

    ecc_parity_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .fold_en   (fold_en),
        .fold_byte (fold_byte),
        .par       (par)
    );

    ecc_readout_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .rd   (dr_rd),
        .pos  (pos)
    );

    assign flash_rd_stb = dr_rd && mode != ECC_READ;
    assign dr_rdata     = (mode == ECC_READ) ? code_byte(par, read_order(pos)) : flash_rdata;

    // R8
    read_nofold_chk: assert property (@(posedge clk) disable iff (rst)
        mode == ECC_READ |=> $stable(par));
    // R8
    no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_mode == 2'b10 |-> !flash_rd_stb);
endmodule

// File: tb/nand_ecc_accum_bench.sv
module nand_ecc_accum_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ecc_mode = 2'b00;
    logic       dr_wr = 1'b0;
    logic [7:0] dr_wdata = 8'h00;
    logic       dr_rd = 1'b0;
    logic [7:0] flash_rdata = 8'h00;
    logic       flash_rd_stb;
    logic [7:0] dr_rdata;

    int n_chk = 0;
    int n_fail = 0;

    bit [15:0] m_lp;
    bit [5:0]  m_cp;
    int        m_addr;
    bit [1:0]  m_mode;

    always #2 clk = ~clk;

    nand_ecc_accum u_nand_ecc_accum (
        .clk(clk), .rst(rst), .ecc_mode(ecc_mode),
        .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd),
        .flash_rdata(flash_rdata), .flash_rd_stb(flash_rd_stb), .dr_rdata(dr_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    // model: fold one byte from its bits
    task automatic model_fold(input bit [7:0] b);
        bit p = 0;
        for (int j = 0; j < 8; j++) begin
            p ^= b[j];
            for (int k = 0; k < 3; k++) begin
                if (j[k]) m_cp[2*k+1] ^= b[j];
                else      m_cp[2*k]   ^= b[j];
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (m_addr[k]) m_lp[2*k+1] ^= p;
            else           m_lp[2*k]   ^= p;
        end
        m_addr = (m_addr + 1) % 256;
    endtask

    function automatic bit [7:0] exp_byte(input int n);
        if (n == 0) return ~m_lp[7:0];
        if (n == 1) return ~m_lp[15:8];
        return {~m_cp, 2'b11};
    endfunction

    task automatic set_mode(input bit [1:0] m);
        @(negedge clk);
        ecc_mode = m;
        m_mode = m;
        if (m == 2'b11) begin
            m_lp = '0;
            m_cp = '0;
            m_addr = 0;
        end
        @(posedge clk);
    endtask

    task automatic wr_byte(input bit [7:0] b);
        @(negedge clk);
        dr_wr = 1'b1;
        dr_wdata = b;
        @(posedge clk);
        #1 dr_wr = 1'b0;
        if (m_mode == 2'b01) model_fold(b);
    endtask

    // R4 R8: flash read outside read-out
    task automatic rd_flash(input bit [7:0] b);
        @(negedge clk);
        dr_rd = 1'b1;
        flash_rdata = b;
        #1;
        check(flash_rd_stb == 1'b1, "R8 strobe", flash_rd_stb, 1);
        check(dr_rdata == b, "R8 pass-through", dr_rdata, b);
        @(posedge clk);
        #1 dr_rd = 1'b0;
        if (m_mode == 2'b01) model_fold(b);
    endtask

    task automatic rd_code(input bit [7:0] e, input string tag);
        @(negedge clk);
        dr_rd = 1'b1;
        flash_rdata = ~e;
        #1;
        check(dr_rdata == e, tag, dr_rdata, e);
        check(flash_rd_stb == 1'b0, "R8 no strobe in read-out", flash_rd_stb, 0);
        @(posedge clk);
        #1 dr_rd = 1'b0;
    endtask

    // R3 R7: off, read-out, three reads in order 1,0,2, off
    task automatic check_code(input string tag);
        set_mode(2'b00);
        set_mode(2'b10);
        rd_code(exp_byte(1), {tag, " R7 first=byte1"});
        rd_code(exp_byte(0), {tag, " R7 second=byte0"});
        rd_code(exp_byte(2), {tag, " R7 third=byte2"});
        set_mode(2'b00);
    endtask

    task automatic start_block();
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
    endtask

    task automatic random_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 2) wr_byte(8'($urandom));
            else              rd_flash(8'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_lp = '0; m_cp = '0; m_addr = 0; m_mode = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8 reset state, off mode pass-through
        @(negedge clk);
        flash_rdata = 8'h5A;
        #1;
        check(dr_rdata == 8'h5A, "R8 reset pass-through", dr_rdata, 8'h5A);
        check(flash_rd_stb == 1'b0, "R8 reset no strobe", flash_rd_stb, 0);
        // R2 reset equals cleared
        check_code("R2 reset");

        // R2 erased block
        start_block();
        for (int i = 0; i < 256; i++) wr_byte(8'hFF);
        check_code("R2 erased");

        // R1 directed single byte 0x01 at address 0
        start_block();
        wr_byte(8'h01);
        set_mode(2'b00);
        set_mode(2'b10);
        rd_code(8'hAA, "R1 directed byte1");
        rd_code(8'hAA, "R1 directed byte0");
        rd_code(8'hAB, "R1 directed byte2");
        set_mode(2'b00);

        // R1 R4 random blocks
        for (int blk = 0; blk < 3; blk++) begin
            start_block();
            random_bytes(256);
            check_code("R4 random block");
        end

        // R5 off mode ignores traffic, then R4 resume
        start_block();
        random_bytes(100);
        set_mode(2'b00);
        random_bytes(20);
        check_code("R5 off hold");
        set_mode(2'b01);
        random_bytes(156);
        check_code("R4 resume");

        // R8 read-out reads do not fold: read twice more
        check_code("R8 no fold");

        // R9 wrap after three reads and restart on mode exit
        set_mode(2'b10);
        rd_code(exp_byte(1), "R9 p0");
        rd_code(exp_byte(0), "R9 p1");
        rd_code(exp_byte(2), "R9 p2");
        rd_code(exp_byte(1), "R9 wrap to byte1");
        rd_code(exp_byte(0), "R9 after wrap byte0");
        set_mode(2'b00);
        set_mode(2'b10);
        rd_code(exp_byte(1), "R9 restart byte1");
        set_mode(2'b00);

        // R6 clear
        set_mode(2'b11);
        check_code("R6 clear");
        check(exp_byte(2) == 8'hFF, "R6 model", exp_byte(2), 8'hFF);

        // R10 more than 256 bytes
        start_block();
        random_bytes(300);
        check_code("R10 address wrap");

        finish_run();
    end
endmodule